// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. After software has launched an embedded program or erase operation, the block decides whether that operation has finished. It does not use a ready flag. While the flash is busy, one status bit inverts on every read. The block therefore issues status reads in pairs and compares that toggle bit between the two reads of each pair. If the toggle bit is the same in both reads, the operation has finished. If it differs, the flash is still working, unless the timeout bit has also risen.

When the timeout bit is seen high, the block makes one more pair of reads. This catches the case where toggling stopped at the same moment the timeout bit rose. If the toggle bit still changes in that extra pair, the operation has failed. The block then issues a reset-command write so that the flash returns to array reads, and reports failure. The host can abort at any time. Any later start begins the algorithm again from the first read of a fresh pair. A pair limit guarantees that the block always ends in a result.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, rd_req_o and wr_req_o are all low.
- R2: A start_i pulse raises busy_o and rd_req_o on the next cycle, with rd_addr_o equal to the addr_i value captured at start. A pending read holds its request and address until rd_ack_i.
- R3: The block reads status in pairs and compares bit TOGGLE_BIT (default 6) of the two reads. If the two values are equal, done_o pulses for one cycle and busy_o falls in that same cycle, with no write issued.
- R4: If the toggle bit differs and bit TIMEOUT_BIT (default 5) is low in both reads of the pair, the block issues another pair of reads.
- R5: If the toggle bit differs and the timeout bit is high in either read of the pair, the block issues exactly one more pair of reads. If the toggle bit is equal in that pair, done_o pulses.
- R6: If the toggle bit still differs in that extra pair, the block requests one write of RESET_CMD (0xF0) to RESET_ADDR. fail_o pulses for one cycle on the cycle after wr_ack_i, and done_o does not pulse.
- R7: After MAX_PAIRS consecutive pairs that toggle with the timeout bit low, the block stops polling and takes the same reset-write and fail path as R6.
- R8: abort_i returns the block to idle on the next cycle. busy_o, rd_req_o and wr_req_o drop, and neither done_o nor fail_o pulses.
- R9: A start after an abort begins with the first read of a new pair. Toggle data captured before the abort is never compared against later reads.
- R10: done_o and fail_o are never high together, and each is high for only one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling from the first read of a pair |
| abort_i | input | 1 | Leave polling and return to idle |
| addr_i | input | ADDR_W | Address to poll, captured at start |
| rd_req_o | output | 1 | Status read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Status read address |
| rd_ack_i | input | 1 | Read acknowledge; rd_data_i is valid in this cycle |
| rd_data_i | input | DATA_W | Returned status byte |
| wr_req_o | output | 1 | Reset-command write request |
| wr_addr_o | output | ADDR_W | Write address (RESET_ADDR) |
| wr_data_o | output | DATA_W | Write data (RESET_CMD) |
| wr_ack_i | input | 1 | Write acknowledge |
| busy_o | output | 1 | High from start until done, fail or abort |
| done_o | output | 1 | One-cycle pulse: operation complete |
| fail_o | output | 1 | One-cycle pulse: operation failed |

## Verification
Some internal faults only show up in the result. A stale or wrongly captured first toggle value makes a read pair report the wrong outcome: done_o appears one pair early, or an extra pair of reads goes out before the result. The bench sees this in the acknowledged read count as soon as the run ends. A wrong recheck path or pair counter turns a failure into a success or the reverse, and changes the number of writes. Other faults show at the ports right away. A state that is not cleared on abort shows on the first cycle after abort_i, as busy_o or a request left high, or on the next run as a changed read count.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD_A  = 3'd1,
    ST_RD_B  = 3'd2,
    ST_CHK_A = 3'd3,
    ST_CHK_B = 3'd4,
    ST_RST_W = 3'd5
  } poll_state_e;
endpackage

// File: rtl/poll_pair_cmp.sv
module poll_pair_cmp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic tog_bit_i,
  input  logic to_bit_i,
  output logic toggled_o,
  output logic timeout_o
);
  logic first_tog_q, first_to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_tog_q <= 1'b0;
      first_to_q  <= 1'b0;
    end else if (capture_i) begin
      first_tog_q <= tog_bit_i;
      first_to_q  <= to_bit_i;
    end
  end

  // compared against the second read of the pair while its ack is present
  assign toggled_o = first_tog_q ^ tog_bit_i;
  assign timeout_o = first_to_q | to_bit_i;
endmodule

// File: rtl/poll_pair_limit.sv
module poll_pair_limit #(
  parameter int unsigned MAX_PAIRS = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CNT_W = $clog2(MAX_PAIRS + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(MAX_PAIRS - 1));
endmodule

// File: rtl/flash_toggle_poller.sv
module flash_toggle_poller #(
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TOGGLE_BIT  = 6,
  parameter int unsigned TIMEOUT_BIT = 5,
  parameter int unsigned MAX_PAIRS   = 1024,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter logic [DATA_W-1:0] RESET_CMD  = DATA_W'('hF0)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_req_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);
  import poll_pkg::*;

  poll_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic done_q, fail_q, done_d, fail_d;
  logic rd_fire, wr_fire, capture, toggled, timeout, pair_last, pair_inc;

  assign rd_req_o  = (state_q == ST_RD_A) || (state_q == ST_RD_B) ||
                     (state_q == ST_CHK_A) || (state_q == ST_CHK_B);
  assign wr_req_o  = (state_q == ST_RST_W);
  assign rd_fire   = rd_req_o & rd_ack_i;
  assign wr_fire   = wr_req_o & wr_ack_i;
  assign capture   = rd_fire & ((state_q == ST_RD_A) || (state_q == ST_CHK_A));
  assign pair_inc  = rd_fire & (state_q == ST_RD_B) & toggled & ~timeout
                     & ~abort_i & ~start_i;

  poll_pair_cmp i_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture),
    .tog_bit_i (rd_data_i[TOGGLE_BIT]),
    .to_bit_i  (rd_data_i[TIMEOUT_BIT]),
    .toggled_o (toggled),
    .timeout_o (timeout)
  );

  poll_pair_limit #(.MAX_PAIRS(MAX_PAIRS)) i_limit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .inc_i  (pair_inc),
    .last_o (pair_last)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
    end else if (start_i) begin
      state_d = ST_RD_A;
    end else begin
      unique case (state_q)
        ST_RD_A:  if (rd_fire) state_d = ST_RD_B;
        ST_RD_B:
          if (rd_fire) begin
            if (!toggled) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else if (timeout) begin
              state_d = ST_CHK_A;
            end else if (pair_last) begin
              state_d = ST_RST_W;
            end else begin
              state_d = ST_RD_A;
            end
          end
        ST_CHK_A: if (rd_fire) state_d = ST_CHK_B;
        ST_CHK_B:
          if (rd_fire) begin
            if (!toggled) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              state_d = ST_RST_W;
            end
          end
        ST_RST_W:
          if (wr_fire) begin
            state_d = ST_IDLE;
            fail_d  = 1'b1;
          end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      if (start_i && !abort_i) addr_q <= addr_i;
    end
  end

  assign rd_addr_o = addr_q;
  assign wr_addr_o = RESET_ADDR;
  assign wr_data_o = RESET_CMD;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign fail_o    = fail_q;
endmodule

// File: rtl/poll_checker.sv
module poll_checker #(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned MAX_PAIRS = 1024
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              abort_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              wr_req_o,
  input logic              wr_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o
);
  int unsigned reads_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  reads_q <= 0;
    else if (start_i)             reads_q <= 0;
    else if (rd_req_o && rd_ack_i) reads_q <= reads_q + 1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rd_req_o && !wr_req_o));

  assert_rd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i && !abort_i && !start_i) |=> (rd_req_o && $stable(rd_addr_o)));

  assert_done_ends_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_fail_after_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> ($past(wr_req_o && wr_ack_i) && !busy_o));

  assert_read_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reads_q <= 2 * MAX_PAIRS + 2);

  assert_abort_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!busy_o && !done_o && !fail_o));

  assert_one_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fail_o) |=> !(done_o || fail_o));

  assert_no_overlap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));
endmodule

bind flash_toggle_poller poll_checker #(.ADDR_W(ADDR_W), .MAX_PAIRS(MAX_PAIRS)) i_poll_checker (.*);

// File: tb/test_flash_toggle_poller.sv
module test_flash_toggle_poller;
  localparam int unsigned AW = 20;
  localparam int unsigned DW = 8;
  localparam int unsigned PAIRS = 4;
  localparam logic [AW-1:0] RST_A = 20'h00555;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rd_req, rd_ack = 1'b0, wr_req, wr_ack = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data = '0, wr_data;
  logic busy, done, fail;

  int total = 0, bad = 0;
  int rd_count = 0, wr_count = 0, rd_idx = 0;
  int done_cnt = 0, fail_cnt = 0, both_cnt = 0, cycles = 0;
  logic hold = 1'b0;
  logic [DW-1:0] seq [0:15];
  logic [DW-1:0] last_wdata;
  logic [AW-1:0] last_waddr;

  always #4 clk = ~clk;

  flash_toggle_poller #(
    .ADDR_W(AW), .DATA_W(DW), .MAX_PAIRS(PAIRS), .RESET_ADDR(RST_A), .RESET_CMD(8'hF0)
  ) i_flash_toggle_poller (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort), .addr_i(addr),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ack_i(wr_ack),
    .busy_o(busy), .done_o(done), .fail_o(fail)
  );

  // flash responder: acknowledges one negedge after a request is seen
  initial forever begin
    @(negedge clk);
    if (rd_req && !rd_ack && !hold) begin
      rd_ack   = 1'b1;
      rd_data  = seq[rd_idx];
      rd_idx   = (rd_idx < 15) ? rd_idx + 1 : rd_idx;
      rd_count = rd_count + 1;
    end else begin
      rd_ack = 1'b0;
    end
    if (wr_req && !wr_ack) begin
      wr_ack     = 1'b1;
      last_wdata = wr_data;
      last_waddr = wr_addr;
      wr_count   = wr_count + 1;
    end else begin
      wr_ack = 1'b0;
    end
  end

  initial forever begin
    @(posedge clk);
    cycles = cycles + 1;
    if (done) done_cnt = done_cnt + 1;
    if (fail) fail_cnt = fail_cnt + 1;
    if (done && fail) both_cnt = both_cnt + 1;
  end

  initial begin
    wait (cycles > 100000);
    bad   = bad + 1;
    total = total + 1;
    $display("FAIL watchdog: run hung, got %0d cycles exp <100000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [DW-1:0] b0, b1, b2, b3, b4, b5, b6, b7);
    seq[0] = b0; seq[1] = b1; seq[2] = b2; seq[3] = b3;
    seq[4] = b4; seq[5] = b5; seq[6] = b6; seq[7] = b7;
    for (int i = 8; i < 16; i++) seq[i] = b7;
    rd_idx = 0;
  endtask

  task automatic run_poll(input string req, input logic [AW-1:0] a, input bit exp_fail,
                          input int exp_reads, input int exp_writes);
    int d0, f0;
    rd_count = 0; wr_count = 0;
    d0 = done_cnt; f0 = fail_cnt;
    @(negedge clk); start = 1'b1; addr = a;
    @(negedge clk); start = 1'b0;
    chk("R2", "busy after start", int'(busy), 1);
    chk("R2", "rd_req after start", int'(rd_req), 1);
    chk("R2", "rd_addr", int'(rd_addr), int'(a));
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done_cnt != d0 || fail_cnt != f0) break;
    end
    chk(req, "done pulses", done_cnt - d0, exp_fail ? 0 : 1);
    chk(req, "fail pulses", fail_cnt - f0, exp_fail ? 1 : 0);
    chk(req, "reads", rd_count, exp_reads);
    chk(req, "writes", wr_count, exp_writes);
    chk("R3", "busy after result", int'(busy), 0);
    if (exp_fail) begin
      chk("R6", "reset cmd data", int'(last_wdata), 'hF0);
      chk("R6", "reset cmd addr", int'(last_waddr), int'(RST_A));
    end
  endtask

  task automatic t_reset();
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "fail", int'(fail), 0);
    chk("R1", "rd_req", int'(rd_req), 0);
    chk("R1", "wr_req", int'(wr_req), 0);
  endtask

  task automatic t_stable_first_pair();   // R3
    load(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    run_poll("R3", 20'h12345, 1'b0, 2, 0);
  endtask

  task automatic t_toggle_then_stop();    // R4
    load(8'h00, 8'h40, 8'h40, 8'h00, 8'h44, 8'h44, 8'h44, 8'h44);
    run_poll("R4", 20'h00100, 1'b0, 6, 0);
  endtask

  task automatic t_timeout_then_stop();   // R5
    load(8'h00, 8'h60, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40);
    run_poll("R5", 20'h00200, 1'b0, 4, 0);
    load(8'h20, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    run_poll("R5", 20'h00201, 1'b0, 4, 0);
  endtask

  task automatic t_timeout_still_toggling(); // R6
    load(8'h00, 8'h60, 8'h20, 8'h60, 8'h60, 8'h60, 8'h60, 8'h60);
    run_poll("R6", 20'h00300, 1'b1, 4, 1);
  endtask

  task automatic t_pair_limit();          // R7
    load(8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40);
    for (int i = 8; i < 16; i++) seq[i] = (i % 2 == 0) ? 8'h00 : 8'h40;
    run_poll("R7", 20'h00400, 1'b1, 2 * PAIRS, 1);
  endtask

  task automatic t_abort_restart();       // R8, R9
    int d0, f0;
    load(8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40);
    rd_count = 0;
    d0 = done_cnt; f0 = fail_cnt;
    @(negedge clk); start = 1'b1; addr = 20'h00500;
    @(negedge clk); start = 1'b0;
    wait (rd_count == 1);
    hold = 1'b1;
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk("R8", "busy after abort", int'(busy), 0);
    chk("R8", "rd_req after abort", int'(rd_req), 0);
    chk("R8", "wr_req after abort", int'(wr_req), 0);
    repeat (4) @(negedge clk);
    chk("R8", "no done on abort", done_cnt - d0, 0);
    chk("R8", "no fail on abort", fail_cnt - f0, 0);
    hold = 1'b0;
    // stored first bit was 0; a restart that skipped the first read would see a toggle
    load(8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40, 8'h40);
    run_poll("R9", 20'h00501, 1'b0, 2, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) seq[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_stable_first_pair();
    t_toggle_then_stop();
    t_timeout_then_stop();
    t_timeout_still_toggling();
    t_pair_limit();
    t_abort_restart();
    chk("R10", "cycles with done and fail together", both_cnt, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule